// File: doc/BRIEF.md
# Next Program Counter Selector

This block holds the program counter of a single-cycle processor and works out where execution goes next. Each cycle it chooses one of four candidates: the sequential address, a branch target, an absolute jump target, or an address read from a general register. The last of these lets a subroutine return to its caller.

The block also exports the sequential address, which is the address of the instruction after the current one. The datapath uses it as the link value that call instructions write into the register file. Decode logic supplies the control flags. The register file supplies the register operand, and the instruction word supplies the jump field and the branch offset.

Plain jumps and jump-and-link both raise only the jump flag. Register-indirect jumps, with or without link, raise the jump flag together with the register-jump flag.

Top module: `pc_next_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, `pc` becomes 0 after that edge.
- R2: `link_addr` always equals `pc + 4`, modulo 2^32.
- R3: When `jump` is 0 and `br_taken` is 0, `pc_next` equals `pc + 4`.
- R4: When `jump` is 0 and `br_taken` is 1, `pc_next` equals `pc + 4 + (sign-extended br_offset × 4)`. Bit 15 of `br_offset` is its sign.
- R5: When `jump` is 1 and `reg_jump` is 0, `pc_next` equals `{pc[31:26], jump_addr[25:0]}`, whatever `br_taken` and `br_offset` are.
- R6: When `jump` and `reg_jump` are both 1, `pc_next` equals `rs_value`, whatever `jump_addr`, `br_taken` and `br_offset` are.
- R7: `reg_jump` has no effect while `jump` is 0; `pc_next` then follows R3 or R4.
- R8: At every rising edge with `rst` low, `pc` loads the value `pc_next` held before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| jump_addr | input | 26 | Address field of an absolute jump |
| br_offset | input | 16 | Signed branch offset, in instruction words |
| br_taken | input | 1 | Branch condition met |
| rs_value | input | 32 | Register operand used as the indirect target |
| jump | input | 1 | Jump of either kind |
| reg_jump | input | 1 | Jump target comes from the register operand |
| pc | output | 32 | Current program counter |
| pc_next | output | 32 | Address loaded at the next edge |
| link_addr | output | 32 | Sequential address, used as the return address |

## Verification
Directed steps cover each flag combination in turn. A branch with a positive offset and one with a negative offset check that the sign extension and the word scaling are right. Jumps are issued with `br_taken` high and with a live offset, so a priority inversion between jump and branch shows up in `pc_next`. Register jumps carry a `jump_addr` that differs from `rs_value`, which separates the register path from the absolute path. A long stretch of mixed random flags, with `reg_jump` often high while `jump` is low, checks that a stray register-jump flag stays inert. The same stretch checks that the upper PC bits carried into absolute targets follow earlier register jumps.

// File: rtl/npc_pkg.sv
package npc_pkg;

    typedef enum logic [1:0] {
        SRC_SEQ    = 2'd0,
        SRC_BRANCH = 2'd1,
        SRC_ABS    = 2'd2,
        SRC_REG    = 2'd3
    } npc_src_e;

    typedef struct packed {
        logic jump;
        logic reg_jump;
        logic br_taken;
    } npc_ctrl_t;

    // Priority: register-indirect, absolute, taken branch, sequential.
    function automatic npc_src_e pick_source(input npc_ctrl_t c);
        if (c.jump && c.reg_jump) return SRC_REG;
        if (c.jump)               return SRC_ABS;
        if (c.br_taken)           return SRC_BRANCH;
        return SRC_SEQ;
    endfunction

endpackage

// File: rtl/npc_seq_adder.sv
module npc_seq_adder #(
    parameter int ADDR_W = 32,
    parameter int STEP   = 4
) (
    input  logic [ADDR_W-1:0] cur,
    output logic [ADDR_W-1:0] seq
);
    localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

    assign seq = cur + STEP_V;
endmodule

// File: rtl/npc_branch_calc.sv
module npc_branch_calc #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 16,
    parameter int SHIFT  = 2
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [OFF_W-1:0]  offset,
    output logic [ADDR_W-1:0] target
);
    localparam int EXT_W = ADDR_W - OFF_W - SHIFT;

    logic [ADDR_W-1:0] scaled;

    assign scaled = {{EXT_W{offset[OFF_W-1]}}, offset, {SHIFT{1'b0}}};
    assign target = base + scaled;
endmodule

// File: rtl/npc_jump_calc.sv
module npc_jump_calc #(
    parameter int ADDR_W  = 32,
    parameter int FIELD_W = 26
) (
    input  logic [ADDR_W-1:0]  cur,
    input  logic [FIELD_W-1:0] field,
    output logic [ADDR_W-1:0]  target
);
    localparam int KEEP_W = ADDR_W - FIELD_W;

    assign target = {cur[ADDR_W-1 -: KEEP_W], field};
endmodule

// File: rtl/npc_target_mux.sv
module npc_target_mux
    import npc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  npc_ctrl_t         ctrl,
    input  logic [ADDR_W-1:0] seq_t,
    input  logic [ADDR_W-1:0] br_t,
    input  logic [ADDR_W-1:0] abs_t,
    input  logic [ADDR_W-1:0] reg_t,
    output logic [ADDR_W-1:0] sel_t
);
    logic [ADDR_W-1:0] cand [0:3];
    npc_src_e          src;

    always_comb begin
        cand[SRC_SEQ]    = seq_t;
        cand[SRC_BRANCH] = br_t;
        cand[SRC_ABS]    = abs_t;
        cand[SRC_REG]    = reg_t;
        src              = pick_source(ctrl);
        sel_t            = cand[src];
    end
endmodule

// File: rtl/pc_next_unit.sv
module pc_next_unit
    import npc_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int FIELD_W = 26,
    parameter int OFF_W   = 16,
    parameter int STEP    = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [FIELD_W-1:0] jump_addr,
    input  logic [OFF_W-1:0]   br_offset,
    input  logic               br_taken,
    input  logic [ADDR_W-1:0]  rs_value,
    input  logic               jump,
    input  logic               reg_jump,
    output logic [ADDR_W-1:0]  pc,
    output logic [ADDR_W-1:0]  pc_next,
    output logic [ADDR_W-1:0]  link_addr
);
    localparam int SHIFT = $clog2(STEP);

    logic [ADDR_W-1:0] seq_addr;
    logic [ADDR_W-1:0] br_addr;
    logic [ADDR_W-1:0] abs_addr;
    npc_ctrl_t         ctrl;

    assign ctrl = '{jump: jump, reg_jump: reg_jump, br_taken: br_taken};

    npc_seq_adder #(.ADDR_W(ADDR_W), .STEP(STEP)) u_seq (
        .cur (pc),
        .seq (seq_addr)
    );

    npc_branch_calc #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .SHIFT(SHIFT)) u_br (
        .base   (seq_addr),
        .offset (br_offset),
        .target (br_addr)
    );

    npc_jump_calc #(.ADDR_W(ADDR_W), .FIELD_W(FIELD_W)) u_abs (
        .cur    (pc),
        .field  (jump_addr),
        .target (abs_addr)
    );

    npc_target_mux #(.ADDR_W(ADDR_W)) u_mux (
        .ctrl  (ctrl),
        .seq_t (seq_addr),
        .br_t  (br_addr),
        .abs_t (abs_addr),
        .reg_t (rs_value),
        .sel_t (pc_next)
    );

    always_ff @(posedge clk) begin
        if (rst) pc <= '0;
        else     pc <= pc_next;
    end

    assign link_addr = seq_addr;
endmodule

// File: rtl/pc_next_unit_chk.sv
module pc_next_unit_chk #(
    parameter int ADDR_W  = 32,
    parameter int FIELD_W = 26,
    parameter int OFF_W   = 16,
    parameter int STEP    = 4
) (
    input logic               clk,
    input logic               rst,
    input logic [FIELD_W-1:0] jump_addr,
    input logic [OFF_W-1:0]   br_offset,
    input logic               br_taken,
    input logic [ADDR_W-1:0]  rs_value,
    input logic               jump,
    input logic               reg_jump,
    input logic [ADDR_W-1:0]  pc,
    input logic [ADDR_W-1:0]  pc_next,
    input logic [ADDR_W-1:0]  link_addr
);
    localparam int KEEP_W = ADDR_W - FIELD_W;
    localparam int SHIFT  = $clog2(STEP);
    localparam int EXT_W  = ADDR_W - OFF_W - SHIFT;

    AST_RESET_ZERO: assert property (@(posedge clk)
        rst |=> pc == '0) else $error("reset"); // R1

    AST_LINK_SEQ: assert property (@(posedge clk) disable iff (rst)
        !rst |=> link_addr == $past(pc) + ADDR_W'(STEP) + (pc - $past(pc)) ) else $error("link"); // R2

    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
        (!jump && !br_taken) |=> pc == $past(link_addr)) else $error("seq"); // R3

    AST_BRANCH_TGT: assert property (@(posedge clk) disable iff (rst)
        (!jump && br_taken) |=> pc == $past(link_addr)
            + {{EXT_W{$past(br_offset[OFF_W-1])}}, $past(br_offset), {SHIFT{1'b0}}})
        else $error("branch"); // R4

    AST_ABS_TGT: assert property (@(posedge clk) disable iff (rst)
        (jump && !reg_jump) |=> pc == {$past(pc[ADDR_W-1 -: KEEP_W]), $past(jump_addr)})
        else $error("abs"); // R5

    AST_REG_TGT: assert property (@(posedge clk) disable iff (rst)
        (jump && reg_jump) |=> pc == $past(rs_value)) else $error("reg"); // R6

    AST_PC_LOAD: assert property (@(posedge clk) disable iff (rst)
        !rst |=> pc == $past(pc_next)) else $error("load"); // R8
endmodule

bind pc_next_unit pc_next_unit_chk #(
    .ADDR_W(ADDR_W), .FIELD_W(FIELD_W), .OFF_W(OFF_W), .STEP(STEP)
) u_chk (
    .clk(clk), .rst(rst), .jump_addr(jump_addr), .br_offset(br_offset),
    .br_taken(br_taken), .rs_value(rs_value), .jump(jump), .reg_jump(reg_jump),
    .pc(pc), .pc_next(pc_next), .link_addr(link_addr)
);

// File: tb/tb_pc_next_unit.sv
`timescale 1ns/1ps
module tb_pc_next_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic [25:0] jump_addr;
    logic [15:0] br_offset;
    logic        br_taken;
    logic [31:0] rs_value;
    logic        jump;
    logic        reg_jump;
    logic [31:0] pc;
    logic [31:0] pc_next;
    logic [31:0] link_addr;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    logic [31:0] ref_pc = 32'd0;
    logic [31:0] pend[$];

    always #10 clk = ~clk;

    pc_next_unit dut (
        .clk(clk), .rst(rst), .jump_addr(jump_addr), .br_offset(br_offset),
        .br_taken(br_taken), .rs_value(rs_value), .jump(jump), .reg_jump(reg_jump),
        .pc(pc), .pc_next(pc_next), .link_addr(link_addr)
    );

    function automatic logic [31:0] model_next(
        logic [31:0] cur, logic [25:0] fa, logic [15:0] off,
        logic bt, logic [31:0] rv, logic j, logic rj);
        longint s;
        s = longint'(cur) + 4;
        if (j && rj) return rv;
        if (j)       return (cur & 32'hFC00_0000) | {6'd0, fa};
        if (bt)      return 32'(s + longint'($signed(off)) * 4);
        return 32'(s);
    endfunction

    function automatic string tag_of(logic bt, logic j, logic rj);
        if (j && rj) return "R6";
        if (j)       return "R5";
        if (rj)      return "R7";
        if (bt)      return "R4";
        return "R3";
    endfunction

    task automatic check(logic [31:0] act, logic [31:0] exp, string req);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(logic r, logic [25:0] fa, logic [15:0] off, logic bt,
                        logic [31:0] rv, logic j, logic rj);
        logic [31:0] e;
        @(negedge clk);
        rst = r; jump_addr = fa; br_offset = off; br_taken = bt;
        rs_value = rv; jump = j; reg_jump = rj;
        #1;
        e = model_next(ref_pc, fa, off, bt, rv, j, rj);
        check(link_addr, ref_pc + 32'd4, "R2");
        check(pc_next, e, tag_of(bt, j, rj));
        pend.push_back(r ? 32'd0 : e);
        @(posedge clk);
        #1;
        ref_pc = pend.pop_front();
        check(pc, ref_pc, r ? "R1" : "R8");
    endtask

    initial begin
        #4000000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; jump_addr = '0; br_offset = '0; br_taken = 0;
        rs_value = '0; jump = 0; reg_jump = 0;
        ref_pc = 32'd0;
        // R1: reset state, PC is zero after the reset edge
        step(1, 26'h0, 16'h0, 0, 32'h0, 0, 0);
        step(1, 26'h0, 16'h0, 0, 32'h0, 0, 0);
        // R3: plain sequential steps
        step(0, 26'h3FF_FFFF, 16'h7FFF, 0, 32'hDEAD_BEEF, 0, 0);
        step(0, 26'h0, 16'h0, 0, 32'h0, 0, 0);
        // R4: forward and backward branches
        step(0, 26'h0, 16'h0010, 1, 32'h0, 0, 0);
        step(0, 26'h0, 16'hFFF8, 1, 32'h0, 0, 0);
        // R5: absolute jump beats a taken branch
        step(0, 26'h123_4567, 16'h0040, 1, 32'h5555_5555, 1, 0);
        // R6: register jump beats branch and absolute field
        step(0, 26'h2AA_AAAA, 16'h0100, 1, 32'hF000_1000, 1, 1);
        // R5: upper PC bits now come from the register target
        step(0, 26'h000_0040, 16'h0, 0, 32'h0, 1, 0);
        // R7: register-jump flag alone is inert
        step(0, 26'h3FF_0000, 16'h0, 0, 32'h0BAD_0000, 0, 1);
        step(0, 26'h3FF_0000, 16'hFFFF, 1, 32'h0BAD_0000, 0, 1);
        // R2/R3: wrap of sequential address at the top of memory
        step(0, 26'h0, 16'h0, 0, 32'hFFFF_FFFC, 1, 1);
        step(0, 26'h0, 16'h0, 0, 32'h0, 0, 0);
        // R1: reset in the middle of operation
        step(0, 26'h0, 16'h0, 0, 32'h8000_0000, 1, 1);
        step(1, 26'h1, 16'h1, 1, 32'h1234_5678, 1, 1);
        // mixed random traffic
        for (int i = 0; i < 400; i++) begin
            logic [31:0] rv;
            logic [3:0]  f;
            rv = $urandom;
            f  = 4'($urandom);
            step(f == 4'hF, 26'($urandom), 16'($urandom), f[0], {rv[31:2], 2'b00},
                 f[1] & f[2], f[3]);
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule